// File: doc/BRIEF.md
# Base-Relative Register Cache

This block replaces a fixed register file with a small set-associative cache. Each operand names a register number. A dedicated adder adds that number to a base pointer to form a word address in memory. The cache looks that address up in the following cycle. The first touch of a location fetches its whole line from backing memory over a valid/ready port. Every later touch hits until the line is evicted.

A task switch reloads only the base pointer and a register-count limit. Lines that belong to an earlier task stay resident. A task that comes back can therefore find its registers still cached. Privileged software sets the limit, so the number of registers a task may use is not fixed in hardware.

The client has one access port, used for both reads and writes. It offers an access while `busy_o` is low and receives a one-cycle `done_o` pulse with the result. Writes to the configuration registers are taken only while the cache is idle.

Top module: `regcache`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `mem_valid_o` are low, the base pointer is 0 and the limit is 0, so every access ends in an error.
- R2: The address of an access is the base pointer plus the zero-extended register number. A line fetch requests the four words of that address's line in ascending order, starting at the line's first word.
- R3: A register number greater than or equal to the limit gives `done_o` and `err_o` together 2 cycles after acceptance. Such an access causes no memory transfer and changes no cached data.
- R4: A read that misses on a clean or empty victim fetches the line and then returns the addressed word with `done_o` 7 cycles after acceptance, when `mem_ready_i` is held high.
- R5: A read that hits returns the cached word with `done_o` 2 cycles after acceptance and causes no memory transfer. `done_o` lasts exactly one cycle.
- R6: A write that hits updates the word in place with no memory transfer. A later read of that register returns the new value.
- R7: A write that misses first fetches the line, then merges the write data into it. The other words of the line keep their memory values.
- R8: Address bits [1:0] select the word and bits [3:2] select one of four sets. Each set holds two lines. A miss replaces the line of that set that was used least recently.
- R9: A dirty victim is written back as four words, in ascending order, before the new line is fetched, so the miss completes 11 cycles after acceptance. Memory then holds the modified data.
- R10: A change of base pointer invalidates nothing. Going back to an earlier base hits on lines that are still resident, with no memory transfer.
- R11: A configuration write offered while `busy_o` is high is ignored.
- R12: A word moves only on a cycle where `mem_valid_o` and `mem_ready_i` are both high. While `mem_ready_i` is low, the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load base pointer and limit (taken only while idle) |
| cfg_base_i | input | 16 | New base pointer (word address) |
| cfg_limit_i | input | 9 | New register-count limit |
| req_valid_i | input | 1 | Access offered; taken on an edge where `busy_o` is low |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_reg_i | input | 8 | Register number |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Access in progress; offers are not taken |
| done_o | output | 1 | One-cycle pulse: access complete |
| err_o | output | 1 | With `done_o`: register number out of range |
| rdata_o | output | 32 | Read result, valid with `done_o` |
| mem_valid_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | 1 = write-back word, 0 = fetch word |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Write-back data |
| mem_ready_i | input | 1 | Memory accepts or returns the word this cycle |
| mem_rdata_i | input | 32 | Fetched word |

## Verification
Every result is counted in cycles from the edge that accepts the access. Errors and hits finish 2 cycles after acceptance, a clean miss 7 cycles after, and a dirty miss 11 cycles after, with memory answering at once. The bench samples on the falling clock edge and counts falling edges from acceptance until `done_o` appears, then compares that count with the expected latency. Memory transfers are logged at the rising edge and checked afterwards for count, direction and address order. During the stalled-memory test the held address is inspected on each falling edge.

// File: rtl/regcache_pkg.sv
package regcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOOK  = 2'd1,
        ST_WBACK = 2'd2,
        ST_FILL  = 2'd3
    } rc_state_e;
endpackage

// File: rtl/regcache_agen.sv
// Base-plus-register adder and range check; feeds the address stage register.
module regcache_agen #(
    parameter int AW = 16,
    parameter int RW = 8
) (
    input  logic [AW-1:0] base_i,
    input  logic [RW:0]   limit_i,
    input  logic [RW-1:0] reg_i,
    output logic [AW-1:0] addr_o,
    output logic          bad_o
);
    localparam int PADW = AW - RW;

    always_comb begin
        addr_o = base_i + {{PADW{1'b0}}, reg_i};
        bad_o  = ({1'b0, reg_i} >= limit_i);
    end
endmodule

// File: rtl/regcache_core.sv
// Two-way set-associative register store with write-back and LRU.
module regcache_core
    import regcache_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int RW    = 8,
    parameter int SETS  = 4,
    parameter int WORDS = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_we_i,
    input  logic [AW-1:0] cfg_base_i,
    input  logic [RW:0]   cfg_limit_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [AW-1:0] gen_addr_i,
    input  logic          gen_bad_i,
    output logic [AW-1:0] base_o,
    output logic [RW:0]   limit_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o,
    output logic          mem_valid_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam int IDXW = $clog2(SETS);
    localparam int OFFW = $clog2(WORDS);
    localparam int TAGW = AW - IDXW - OFFW;
    localparam logic [OFFW-1:0] LAST = OFFW'(WORDS - 1);

    typedef struct packed {
        rc_state_e                                  st;
        logic [AW-1:0]                              base;
        logic [RW:0]                                limit;
        logic [AW-1:0]                              addr;
        logic                                       wr;
        logic                                       bad;
        logic [DW-1:0]                              wdata;
        logic [OFFW-1:0]                            cnt;
        logic                                       vic;
        logic [1:0][SETS-1:0]                       vld;
        logic [1:0][SETS-1:0]                       dty;
        logic [1:0][SETS-1:0][TAGW-1:0]             tag;
        logic [1:0][SETS-1:0][WORDS-1:0][DW-1:0]    dat;
        logic [SETS-1:0]                            lru;
        logic                                       done;
        logic                                       err;
        logic [DW-1:0]                              rdata;
    } core_t;

    core_t q, d;

    logic [IDXW-1:0] idx;
    logic [TAGW-1:0] tg;
    logic [OFFW-1:0] off;
    logic            hit0, hit1, hit, hway;

    always_comb begin
        idx  = q.addr[OFFW +: IDXW];
        tg   = q.addr[AW-1 -: TAGW];
        off  = q.addr[OFFW-1:0];
        hit0 = q.vld[0][idx] && (q.tag[0][idx] == tg);
        hit1 = q.vld[1][idx] && (q.tag[1][idx] == tg);
        hit  = hit0 || hit1;
        hway = hit1;
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cfg_we_i) begin
                    d.base  = cfg_base_i;
                    d.limit = cfg_limit_i;
                end
                if (req_valid_i) begin
                    d.addr  = gen_addr_i;
                    d.bad   = gen_bad_i;
                    d.wr    = req_write_i;
                    d.wdata = req_wdata_i;
                    d.st    = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (q.bad) begin
                    d.done = 1'b1;
                    d.err  = 1'b1;
                    d.st   = ST_IDLE;
                end else if (hit) begin
                    if (q.wr) begin
                        d.dat[hway][idx][off] = q.wdata;
                        d.dty[hway][idx]      = 1'b1;
                    end else begin
                        d.rdata = q.dat[hway][idx][off];
                    end
                    d.lru[idx] = ~hway;
                    d.done     = 1'b1;
                    d.st       = ST_IDLE;
                end else begin
                    d.vic             = q.lru[idx];
                    d.cnt             = '0;
                    d.vld[q.lru[idx]][idx] = 1'b0;
                    d.st = (q.vld[q.lru[idx]][idx] && q.dty[q.lru[idx]][idx])
                           ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ready_i) begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ready_i) begin
                    d.dat[q.vic][idx][q.cnt] = mem_rdata_i;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST) begin
                        d.vld[q.vic][idx] = 1'b1;
                        d.dty[q.vic][idx] = 1'b0;
                        d.tag[q.vic][idx] = tg;
                        d.st              = ST_LOOK;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        base_o      = q.base;
        limit_o     = q.limit;
        busy_o      = (q.st != ST_IDLE);
        done_o      = q.done;
        err_o       = q.err;
        rdata_o     = q.rdata;
        mem_valid_o = (q.st == ST_WBACK) || (q.st == ST_FILL);
        mem_we_o    = (q.st == ST_WBACK);
        mem_addr_o  = (q.st == ST_WBACK) ? {q.tag[q.vic][idx], idx, q.cnt}
                                         : {tg, idx, q.cnt};
        mem_wdata_o = q.dat[q.vic][idx][q.cnt];
    end

    // R12: a stalled word request keeps its address
    p_mem_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));

    // R11: configuration frozen while an access is in flight
    p_cfg_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st != ST_IDLE) |=> ($stable(q.base) && $stable(q.limit)));

    // R3: an out-of-range lookup ends at once with an error and no traffic
    p_range_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_LOOK && q.bad) |=> (err_o && done_o && !mem_valid_o));

    // R4: the last fill word leaves a valid, clean line that the lookup hits
    p_fill_lands_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == ST_FILL && mem_ready_i && q.cnt == LAST) |=> (hit && !q.dty[q.vic][idx]));

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

// File: rtl/regcache.sv
module regcache #(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int RW    = 8,
    parameter int SETS  = 4,
    parameter int WORDS = 4
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cfg_we_i,
    input  logic [AW-1:0] cfg_base_i,
    input  logic [RW:0]   cfg_limit_i,
    input  logic          req_valid_i,
    input  logic          req_write_i,
    input  logic [RW-1:0] req_reg_i,
    input  logic [DW-1:0] req_wdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic [DW-1:0] rdata_o,
    output logic          mem_valid_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic          mem_ready_i,
    input  logic [DW-1:0] mem_rdata_i
);
    logic [AW-1:0] base, gen_addr;
    logic [RW:0]   limit;
    logic          gen_bad;

    regcache_agen #(.AW(AW), .RW(RW)) u_agen (
        .base_i  (base),
        .limit_i (limit),
        .reg_i   (req_reg_i),
        .addr_o  (gen_addr),
        .bad_o   (gen_bad)
    );

    regcache_core #(.AW(AW), .DW(DW), .RW(RW), .SETS(SETS), .WORDS(WORDS)) u_core (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cfg_we_i    (cfg_we_i),
        .cfg_base_i  (cfg_base_i),
        .cfg_limit_i (cfg_limit_i),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_wdata_i (req_wdata_i),
        .gen_addr_i  (gen_addr),
        .gen_bad_i   (gen_bad),
        .base_o      (base),
        .limit_o     (limit),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .rdata_o     (rdata_o),
        .mem_valid_o (mem_valid_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_ready_i (mem_ready_i),
        .mem_rdata_i (mem_rdata_i)
    );
endmodule

// File: tb/test_regcache.sv
`timescale 1ns/1ps
module test_regcache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_base = '0;
    logic [8:0]  cfg_limit = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [7:0]  req_reg = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, err, mem_valid, mem_we;
    logic [31:0] rdata, mem_wdata, mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rdy = 1'b1;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [31:0] mem [0:1023];
    logic [15:0] lg_addr [0:127];
    logic        lg_we [0:127];
    int nxf = 0;

    always #2.5 clk = ~clk;

    regcache i_regcache (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_base_i(cfg_base),
        .cfg_limit_i(cfg_limit), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_reg_i(req_reg), .req_wdata_i(req_wdata), .busy_o(busy), .done_o(done),
        .err_o(err), .rdata_o(rdata), .mem_valid_o(mem_valid), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_rdy),
        .mem_rdata_i(mem_rdata)
    );

    function automatic logic [31:0] init_val(input logic [15:0] a);
        return 32'hC0DE_0000 | {16'h0, a};
    endfunction

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_rdy) begin
            lg_addr[nxf[6:0]] <= mem_addr;
            lg_we[nxf[6:0]]   <= mem_we;
            if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            nxf <= nxf + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [15:0] b, input logic [8:0] l);
        @(negedge clk);
        while (busy) @(negedge clk);
        cfg_we = 1'b1; cfg_base = b; cfg_limit = l;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic acc(input logic w, input logic [7:0] r, input logic [31:0] wd,
                       output logic [31:0] rd, output logic e, output int lat,
                       output int nrd, output int nwr, output int start);
        @(negedge clk);
        while (busy) @(negedge clk);
        start = nxf;
        req_valid = 1'b1; req_write = w; req_reg = r; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        rd = rdata; e = err;
        nrd = 0; nwr = 0;
        for (int k = start; k < nxf; k++) begin
            if (lg_we[k[6:0]]) nwr++; else nrd++;
        end
    endtask

    logic [31:0] rd;
    logic e;
    int lat, nrd, nwr, st;

    task automatic t_reset();
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 mem_valid", 32'(mem_valid), 0);
        acc(0, 8'd0, 0, rd, e, lat, nrd, nwr, st);
        chk("R1 err with zero limit", 32'(e), 1);
        chk("R1 no traffic", 32'(nrd + nwr), 0);
    endtask

    task automatic t_first_miss();
        cfg(16'h0100, 9'd16);
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R4 miss latency", 32'(lat), 7);
        chk("R4 data", rd, init_val(16'h0105));
        chk("R4 err low", 32'(e), 0);
        chk("R2 fetch count", 32'(nrd), 4);
        for (int k = 0; k < 4; k++)
            chk("R2 fill order", 32'(lg_addr[(st + k) & 127]), 32'(16'h0104 + k));
    endtask

    task automatic t_hit();
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R5 hit latency", 32'(lat), 2);
        chk("R5 hit data", rd, init_val(16'h0105));
        chk("R5 no traffic", 32'(nrd + nwr), 0);
        acc(0, 8'd7, 0, rd, e, lat, nrd, nwr, st);
        chk("R5 same line hit", rd, init_val(16'h0107));
        chk("R5 same line latency", 32'(lat), 2);
    endtask

    task automatic t_write_hit();
        acc(1, 8'd6, 32'hDEAD_0006, rd, e, lat, nrd, nwr, st);
        chk("R6 write hit latency", 32'(lat), 2);
        chk("R6 no traffic", 32'(nrd + nwr), 0);
        acc(0, 8'd6, 0, rd, e, lat, nrd, nwr, st);
        chk("R6 readback", rd, 32'hDEAD_0006);
    endtask

    task automatic t_limit();
        acc(1, 8'd16, 32'h1111_1111, rd, e, lat, nrd, nwr, st);
        chk("R3 err", 32'(e), 1);
        chk("R3 latency", 32'(lat), 2);
        chk("R3 no traffic", 32'(nrd + nwr), 0);
        acc(0, 8'd15, 0, rd, e, lat, nrd, nwr, st);
        chk("R3 top register allowed", 32'(e), 0);
        chk("R3 top register data", rd, init_val(16'h010F));
    endtask

    task automatic t_write_miss();
        acc(1, 8'd9, 32'hBEEF_0009, rd, e, lat, nrd, nwr, st);
        chk("R7 latency", 32'(lat), 7);
        chk("R7 fetch count", 32'(nrd), 4);
        acc(0, 8'd9, 0, rd, e, lat, nrd, nwr, st);
        chk("R7 merged word", rd, 32'hBEEF_0009);
        acc(0, 8'd8, 0, rd, e, lat, nrd, nwr, st);
        chk("R7 neighbour kept", rd, init_val(16'h0108));
    endtask

    task automatic t_switch_lru_wb();
        cfg(16'h0200, 9'd16);
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R8 second way fill", 32'(lat), 7);
        chk("R8 second way data", rd, init_val(16'h0205));
        cfg(16'h0100, 9'd16);
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R10 return hit latency", 32'(lat), 2);
        chk("R10 return no traffic", 32'(nrd + nwr), 0);
        cfg(16'h0300, 9'd16);
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R8 LRU evicts clean line", 32'(nwr), 0);
        chk("R8 LRU latency", 32'(lat), 7);
        cfg(16'h0400, 9'd16);
        acc(0, 8'd5, 0, rd, e, lat, nrd, nwr, st);
        chk("R9 dirty miss latency", 32'(lat), 11);
        chk("R9 writeback count", 32'(nwr), 4);
        chk("R9 writeback first", 32'(lg_we[st & 127]), 1);
        for (int k = 0; k < 4; k++)
            chk("R9 writeback order", 32'(lg_addr[(st + k) & 127]), 32'(16'h0104 + k));
        chk("R9 memory updated", mem[10'h106], 32'hDEAD_0006);
        cfg(16'h0100, 9'd16);
        acc(0, 8'd6, 0, rd, e, lat, nrd, nwr, st);
        chk("R9 refetch dirty data", rd, 32'hDEAD_0006);
    endtask

    task automatic t_cfg_busy();
        @(negedge clk);
        while (busy) @(negedge clk);
        mem_rdy = 1'b0;
        st = nxf;
        req_valid = 1'b1; req_write = 1'b0; req_reg = 8'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = 16'h0700; cfg_limit = 9'd1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            chk("R12 request held", 32'(mem_valid), 1);
            chk("R12 address held", 32'(mem_addr), 32'h0100);
        end
        chk("R12 no transfer while not ready", 32'(nxf - st), 0);
        mem_rdy = 1'b1;
        lat = 0;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R12 stalled fill data", rdata, init_val(16'h0100));
        acc(0, 8'd12, 0, rd, e, lat, nrd, nwr, st);
        chk("R11 limit unchanged", 32'(e), 0);
        chk("R11 base unchanged", rd, init_val(16'h010C));
        chk("R11 hit without traffic", 32'(nrd + nwr), 0);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) mem[k] = init_val(16'(k));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_miss();
        t_hit();
        t_write_hit();
        t_limit();
        t_write_miss();
        t_switch_lru_wb();
        t_cfg_busy();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule